// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block gathers three alarm sources of an optical transmitter (synthesizer out of lock, junction over-temperature, and elastic-buffer overflow or underflow). It latches each one on its rising edge into a sticky status register that software reads and clears. A per-source enable register chooses which latched alarms may raise a single interrupt pin. The pin's active level can be inverted. It can drive both levels (push-pull) or only its asserted level (open-drain, through an output enable).

The same register port also decides where three transmitter settings come from: parity sense, multiplexing ratio and parallel clock direction. Each setting has a source bit that picks either the register value or the value on a dedicated pin. A global mode input forces every setting to its pin whenever it is LOW. Registers are reached through a plain address, write-data and write-strobe port with a combinational read-data output.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A rising edge on `alarm_src[i]` (bit 0 lock loss, bit 1 over-temperature, bit 2 buffer over/underflow) sets bit i of the status register at address 0x00 on the same clock edge at which the rise is first sampled. The bit stays set after the source falls.
- R2: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a rising edge and a clear arrive in the same cycle, the set wins.
- R3: Status bits 7:3 and enable-register bits 7:3 (address 0x01) always read 0.
- R4: The interrupt is asserted one clock after the OR of (status AND enable) becomes 1, and deasserted one clock after it becomes 0. An alarm whose enable bit is 0 never asserts it.
- R5: In push-pull mode (address 0x02 bit 1 = 0), `irq_oe` is 1. `irq_out` equals the asserted state when bit 0 is 0, and its complement when bit 0 is 1.
- R6: In open-drain mode (address 0x02 bit 1 = 1), `irq_oe` is 1 only while the interrupt is asserted, and `irq_out` is then 1, or 0 when bit 0 of 0x02 is 1.
- R7: In the register at address 0x03, bit 0 is parity-odd, bits 2:1 are the ratio code (00 16:1, 01 10:1, 10 8:1, 11 4:1) and bit 3 is clock direction. Bits 4, 5 and 6 select the register value (1) or the pin value (0) for parity, ratio and clock direction.
- R8: While `host_mode` is 0, all three settings follow their pins, whatever the select bits are.
- R9: After reset the status, enable and interrupt-config registers are 0x00 and 0x03 holds 0x70, so the ratio output is 00 (16:1) with `host_mode` HIGH.
- R10: Address 0x04 reads the live source levels in bits 2:0 and ignores writes. Reads from addresses above 0x04 return 0x00, and writes to them have no effect.
- R11: A source held HIGH does not set its status bit again after the bit is cleared; only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| alarm_src | input | 3 | Alarm source levels, synchronous to clk |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| host_mode | input | 1 | 1: register-capable control, 0: pins forced |
| pin_parity_odd | input | 1 | Parity sense pin |
| pin_ratio | input | 2 | Ratio code pins |
| pin_clk_dir | input | 1 | Clock direction pin |
| cfg_parity_odd | output | 1 | Effective parity sense |
| cfg_ratio | output | 2 | Effective ratio code |
| cfg_clk_dir | output | 1 | Effective clock direction |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A source rise driven between edges shows in the status read right after the next edge, and the interrupt follows one edge later. A write to the enable register likewise moves the interrupt only at the edge after the write edge. Changes to polarity, drive mode and setting source act combinationally once the writing edge has passed. Stimulus is applied at falling edges, and each task samples at the falling edge after exactly the number of rising edges due. Some checks also look one edge early to confirm that the interrupt has not yet moved.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
   localparam logic [ADDR_W-1:0] A_ENABLE = 8'h01;
   localparam logic [ADDR_W-1:0] A_IRQCFG = 8'h02;
   localparam logic [ADDR_W-1:0] A_SETCFG = 8'h03;
   localparam logic [ADDR_W-1:0] A_LIVE   = 8'h04;

   // field positions inside the setting-config register
   localparam int F_PAR     = 0;
   localparam int F_RATIO   = 1;
   localparam int F_CLKDIR  = 3;
   localparam int F_SELPAR  = 4;
   localparam int F_SELRAT  = 5;
   localparam int F_SELCLK  = 6;

   localparam logic [DATA_W-1:0] SETCFG_RST = 8'h70;

   typedef enum logic [1:0] {
      RATIO_16 = 2'b00,
      RATIO_10 = 2'b01,
      RATIO_8  = 2'b10,
      RATIO_4  = 2'b11
   } ratio_e;
endpackage

// File: rtl/alarm_sticky.sv
module alarm_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   initial begin
      if (N < 1) $error("alarm_sticky: N must be at least 1");
   end

   logic [N-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic rise;
      assign rise = src[i] & ~src_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       status[i] <= 1'b0;
         else if (rise)    status[i] <= 1'b1;
         else if (clr[i])  status[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_driver.sv
module irq_driver #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] enable,
   input  logic         invert,
   input  logic         open_drain,
   output logic         active,
   output logic         pin_out,
   output logic         pin_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active <= 1'b0;
      else        active <= |(status & enable);
   end

   always_comb begin
      if (open_drain) begin
         pin_oe  = active;
         pin_out = ~invert;
      end else begin
         pin_oe  = 1'b1;
         pin_out = active ^ invert;
      end
   end
endmodule

// File: rtl/cfg_src_sel.sv
module cfg_src_sel #(
   parameter int W = 1
) (
   input  logic         host_mode,
   input  logic         use_reg,
   input  logic [W-1:0] reg_val,
   input  logic [W-1:0] pin_val,
   output logic [W-1:0] eff_val
);
   initial begin
      if (W < 1) $error("cfg_src_sel: W must be at least 1");
   end

   assign eff_val = (host_mode && use_reg) ? reg_val : pin_val;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
   import alarm_irq_pkg::*;
#(
   parameter int NUM_ALARMS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_ALARMS-1:0] alarm_src,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              host_mode,
   input  logic              pin_parity_odd,
   input  logic [1:0]        pin_ratio,
   input  logic              pin_clk_dir,
   output logic              cfg_parity_odd,
   output logic [1:0]        cfg_ratio,
   output logic              cfg_clk_dir,
   output logic              irq_out,
   output logic              irq_oe
);
   localparam int PAD_W = DATA_W - NUM_ALARMS;

   initial begin
      if (NUM_ALARMS < 1 || NUM_ALARMS >= DATA_W)
         $error("alarm_irq_ctrl: NUM_ALARMS out of range");
   end

   logic [NUM_ALARMS-1:0] status_q;
   logic [NUM_ALARMS-1:0] enable_q;
   logic [1:0]            irqcfg_q;
   logic [DATA_W-1:0]     setcfg_q;
   logic [NUM_ALARMS-1:0] clr;
   logic                  irq_act;
   logic                  cfg_inv;
   logic                  cfg_od;

   assign cfg_inv = irqcfg_q[0];
   assign cfg_od  = irqcfg_q[1];
   assign clr = (bus_we && bus_addr == A_STATUS) ? bus_wdata[NUM_ALARMS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         irqcfg_q <= '0;
         setcfg_q <= SETCFG_RST;
      end else if (bus_we) begin
         case (bus_addr)
            A_ENABLE: enable_q <= bus_wdata[NUM_ALARMS-1:0];
            A_IRQCFG: irqcfg_q <= bus_wdata[1:0];
            A_SETCFG: setcfg_q <= {1'b0, bus_wdata[6:0]};
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         A_STATUS: bus_rdata = {{PAD_W{1'b0}}, status_q};
         A_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable_q};
         A_IRQCFG: bus_rdata = {{(DATA_W-2){1'b0}}, irqcfg_q};
         A_SETCFG: bus_rdata = setcfg_q;
         A_LIVE:   bus_rdata = {{PAD_W{1'b0}}, alarm_src};
         default:  bus_rdata = '0;
      endcase
   end

   alarm_sticky #(.N(NUM_ALARMS)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (alarm_src),
      .clr    (clr),
      .status (status_q)
   );

   irq_driver #(.N(NUM_ALARMS)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .status     (status_q),
      .enable     (enable_q),
      .invert     (cfg_inv),
      .open_drain (cfg_od),
      .active     (irq_act),
      .pin_out    (irq_out),
      .pin_oe     (irq_oe)
   );

   cfg_src_sel #(.W(1)) u_sel_par (
      .host_mode (host_mode),
      .use_reg   (setcfg_q[F_SELPAR]),
      .reg_val   (setcfg_q[F_PAR]),
      .pin_val   (pin_parity_odd),
      .eff_val   (cfg_parity_odd)
   );

   cfg_src_sel #(.W(2)) u_sel_ratio (
      .host_mode (host_mode),
      .use_reg   (setcfg_q[F_SELRAT]),
      .reg_val   (setcfg_q[F_RATIO+1:F_RATIO]),
      .pin_val   (pin_ratio),
      .eff_val   (cfg_ratio)
   );

   cfg_src_sel #(.W(1)) u_sel_clk (
      .host_mode (host_mode),
      .use_reg   (setcfg_q[F_SELCLK]),
      .reg_val   (setcfg_q[F_CLKDIR]),
      .pin_val   (pin_clk_dir),
      .eff_val   (cfg_clk_dir)
   );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
   parameter int NUM_ALARMS = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_ALARMS-1:0] alarm_src,
   input logic [7:0]            bus_addr,
   input logic [7:0]            bus_wdata,
   input logic                  bus_we,
   input logic [7:0]            bus_rdata,
   input logic                  host_mode,
   input logic [1:0]            pin_ratio,
   input logic [1:0]            cfg_ratio,
   input logic [NUM_ALARMS-1:0] status_q,
   input logic [NUM_ALARMS-1:0] enable_q,
   input logic                  irq_act,
   input logic                  cfg_od,
   input logic                  irq_oe,
   input logic                  irq_out
);
   for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
      // R1
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(alarm_src[i]) |=> status_q[i]);
      // R2
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == 8'h00 && bus_wdata[i] && !alarm_src[i]) |=> !status_q[i]);
   end

   // R3
   status_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 8'h00) |-> (bus_rdata[7:NUM_ALARMS] == '0));

   // R4
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_act == |($past(status_q & enable_q))));

   // R5
   pushpull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_od |-> irq_oe);

   // R6
   od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_od && !irq_act) |-> !irq_oe);

   // R8
   pin_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_mode |-> (cfg_ratio == pin_ratio));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > 8'h04) |-> (bus_rdata == 8'h00));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .alarm_src (alarm_src),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .host_mode (host_mode),
   .pin_ratio (pin_ratio),
   .cfg_ratio (cfg_ratio),
   .status_q  (status_q),
   .enable_q  (enable_q),
   .irq_act   (irq_act),
   .cfg_od    (cfg_od),
   .irq_oe    (irq_oe),
   .irq_out   (irq_out)
);

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] alarm_src = '0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       host_mode = 1'b1;
   logic       pin_parity_odd = 1'b0;
   logic [1:0] pin_ratio = 2'b00;
   logic       pin_clk_dir = 1'b0;
   logic       cfg_parity_odd;
   logic [1:0] cfg_ratio;
   logic       cfg_clk_dir;
   logic       irq_out;
   logic       irq_oe;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   alarm_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .alarm_src(alarm_src),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_rdata(bus_rdata), .host_mode(host_mode),
      .pin_parity_odd(pin_parity_odd), .pin_ratio(pin_ratio),
      .pin_clk_dir(pin_clk_dir), .cfg_parity_odd(cfg_parity_odd),
      .cfg_ratio(cfg_ratio), .cfg_clk_dir(cfg_clk_dir),
      .irq_out(irq_out), .irq_oe(irq_oe)
   );

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one rising edge, then settle at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'h00, d); check("R9 status", d, 8'h00);
      rd(8'h01, d); check("R9 enable", d, 8'h00);
      rd(8'h02, d); check("R9 irqcfg", d, 8'h00);
      rd(8'h03, d); check("R9 setcfg", d, 8'h70);
      check("R9 ratio 16:1", cfg_ratio, 2'b00);
      check("R9 irq idle level", irq_out, 0);
      check("R9 irq oe", irq_oe, 1);
   endtask

   task automatic t_sticky();
      logic [7:0] d;
      alarm_src = 3'b001; tick();
      rd(8'h00, d); check("R1 lock bit set", d, 8'h01);
      alarm_src = 3'b000; tick(); tick();
      rd(8'h00, d); check("R1 bit held after source low", d, 8'h01);
      alarm_src = 3'b100; tick();
      rd(8'h00, d); check("R1 fifo bit set", d, 8'h05);
      wr(8'h00, 8'h04);
      tick();
      rd(8'h00, d); check("R11 held level no re-set", d, 8'h01);
      alarm_src = 3'b000; tick();
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      wr(8'h00, 8'h00);
      rd(8'h00, d); check("R2 write 0 keeps bit", d, 8'h01);
      wr(8'h00, 8'hFF);
      rd(8'h00, d); check("R2 write 1 clears", d, 8'h00);
      alarm_src = 3'b111; tick();
      rd(8'h00, d); check("R3 status pad zero", d, 8'h07);
      alarm_src = 3'b000;
      wr(8'h00, 8'h07);
      rd(8'h00, d); check("R2 clear all", d, 8'h00);
      alarm_src = 3'b010;
      wr(8'h00, 8'h02);
      rd(8'h00, d); check("R2 set wins over clear", d, 8'h02);
      alarm_src = 3'b000;
      wr(8'h00, 8'h02);
      wr(8'h01, 8'hF8);
      rd(8'h01, d); check("R3 enable pad zero", d, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      alarm_src = 3'b010; tick();
      alarm_src = 3'b000; tick(); tick();
      check("R4 disabled alarm no irq", irq_out, 0);
      wr(8'h01, 8'h02);
      check("R4 irq not yet at write edge", irq_out, 0);
      tick();
      check("R4 irq one clock after enable", irq_out, 1);
      wr(8'h01, 8'h01);
      check("R4 irq still set at write edge", irq_out, 1);
      tick();
      check("R4 irq drops after disable", irq_out, 0);
      rd(8'h00, d); check("R4 status unaffected", d, 8'h02);
   endtask

   task automatic t_polarity();
      wr(8'h01, 8'h02); tick();
      wr(8'h02, 8'h01);
      check("R5 inverted asserted level", irq_out, 0);
      check("R5 oe push-pull", irq_oe, 1);
      wr(8'h01, 8'h00); tick();
      check("R5 inverted idle level", irq_out, 1);
   endtask

   task automatic t_od();
      wr(8'h02, 8'h02);
      check("R6 od idle oe", irq_oe, 0);
      wr(8'h01, 8'h02); tick();
      check("R6 od asserted oe", irq_oe, 1);
      check("R6 od asserted level", irq_out, 1);
      wr(8'h02, 8'h03);
      check("R6 od inverted level", irq_out, 0);
      check("R6 od inverted oe", irq_oe, 1);
      wr(8'h00, 8'h07); tick();
      check("R6 od released after clear", irq_oe, 0);
      wr(8'h02, 8'h00);
      wr(8'h01, 8'h00);
   endtask

   task automatic t_select();
      host_mode = 1'b1;
      pin_parity_odd = 1'b1; pin_ratio = 2'b11; pin_clk_dir = 1'b1;
      wr(8'h03, 8'h72);
      check("R7 ratio from reg", cfg_ratio, 2'b01);
      check("R7 parity from reg", cfg_parity_odd, 0);
      check("R7 clkdir from reg", cfg_clk_dir, 0);
      wr(8'h03, 8'h42);
      check("R7 parity from pin", cfg_parity_odd, 1);
      check("R7 ratio from pin", cfg_ratio, 2'b11);
      check("R7 clkdir still reg", cfg_clk_dir, 0);
   endtask

   task automatic t_global();
      wr(8'h03, 8'h72);
      host_mode = 1'b0; #0.5;
      check("R8 ratio forced pin", cfg_ratio, 2'b11);
      check("R8 parity forced pin", cfg_parity_odd, 1);
      check("R8 clkdir forced pin", cfg_clk_dir, 1);
      host_mode = 1'b1; #0.5;
      check("R8 ratio back to reg", cfg_ratio, 2'b01);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      alarm_src = 3'b101; #0.5;
      rd(8'h04, d); check("R10 live levels", d, 8'h05);
      wr(8'h04, 8'hFF);
      rd(8'h04, d); check("R10 live write ignored", d, 8'h05);
      alarm_src = 3'b000; #0.5;
      rd(8'h04, d); check("R10 live follows source", d, 8'h00);
      wr(8'h00, 8'h07);
      wr(8'h09, 8'hFF);
      rd(8'h09, d); check("R10 unmapped reads zero", d, 8'h00);
      rd(8'h01, d); check("R10 unmapped write no effect enable", d, 8'h00);
      rd(8'h03, d); check("R10 unmapped write no effect setcfg", d, 8'h72);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sticky();
      t_w1c();
      t_mask();
      t_polarity();
      t_od();
      t_select();
      t_global();
      t_regmap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule